// File: doc/BRIEF.md
# I2C Controller Raw Interrupt Status

This block keeps the raw, unmasked interrupt status of an I2C controller that can work as bus master or as slave. The serial bus engine reports events as single-cycle pulses: an acknowledged general call, a start or repeated start, a stop, bus activity, a NACK on a slave-transmitted byte, a transmit abort and a read request from a remote master. Each event latches a sticky bit. The bit stays set until the CPU reads the clear address for that bit, reads the clear-all address, or disables the controller.

The block also counts the fill level of the transmit FIFO from push and pop strobes. From that count it derives a level-based "transmit below threshold" status bit. It produces a flush control that holds the FIFO empty while the controller is disabled or a transmit abort is pending. It also asserts an SCL-stretch request while a read request waits for service. Interrupt masking, the abort-reason register and the serial engine are outside this block.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset, `rawStat` is 16'h0000 (controller disabled, engine idle) and `txLevel` is 0.
- R2: The `rawStat` bit positions are fixed. Bit 11 is general call, bit 10 is start, bit 9 is stop, bit 8 is activity, bit 7 is RX done, bit 6 is transmit abort, bit 5 is read request and bit 4 is TX-below-threshold. Bits 15:12 and 3:0 always read 0.
- R3: While `ctrlEn` is 1, an event pulse sets its status bit on the next clock edge. The bit stays set on later cycles with no further event.
- R4: A dedicated clear strobe clears only its own bit, effective on the next clock edge. The other status bits keep their values.
- R5: `clrAll` clears all seven sticky bits on the next edge. It leaves the TX-below-threshold bit unchanged.
- R6: When an event pulse and a clear of the same bit (dedicated or `clrAll`) arrive in one cycle, the bit ends up set.
- R7: While `ctrlEn` is 0, all sticky bits are 0 from the next edge onward, and event pulses are ignored.
- R8: While `ctrlEn` is 1, bit 4 is 1 exactly when `txLevel` is less than or equal to `txThresh`.
- R9: While `ctrlEn` is 0, `txLevel` is held at 0, pushes are ignored, `txFlush` is 1, and bit 4 follows `engineBusy`.
- R10: A transmit abort pulse, or a pending abort bit, forces `txLevel` to 0 and makes pushes ignored. After the abort bit is cleared, pushes are accepted again.
- R11: `sclHold` is 1 from the edge after a read-request pulse until the edge on which its clear is taken.
- R12: A push adds 1 to `txLevel` and a pop subtracts 1. Both in one cycle, with the level strictly between 0 and FIFO_DEPTH, leave it unchanged. A push at FIFO_DEPTH is ignored, and a pop at 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlEn | input | 1 | Controller enable |
| txThresh | input | LVL_W | TX threshold level |
| engineBusy | input | 1 | Master or slave state machine active |
| evGenCall | input | 1 | General call acknowledged pulse |
| evStart | input | 1 | Start or repeated start pulse |
| evStop | input | 1 | Stop pulse |
| evActivity | input | 1 | Bus activity pulse |
| evRxDone | input | 1 | Slave-transmit NACK pulse |
| evTxAbort | input | 1 | Transmit abort pulse |
| evRdReq | input | 1 | Remote read request pulse |
| txPush | input | 1 | CPU write into the TX FIFO |
| txPop | input | 1 | Engine takes a byte from the TX FIFO |
| clrGenCall | input | 1 | Read strobe of the general-call clear address |
| clrStart | input | 1 | Read strobe of the start clear address |
| clrStop | input | 1 | Read strobe of the stop clear address |
| clrActivity | input | 1 | Read strobe of the activity clear address |
| clrRxDone | input | 1 | Read strobe of the RX-done clear address |
| clrTxAbort | input | 1 | Read strobe of the abort clear address |
| clrRdReq | input | 1 | Read strobe of the read-request clear address |
| clrAll | input | 1 | Read strobe of the clear-all address |
| rawStat | output | 16 | Raw status word |
| txLevel | output | LVL_W | TX FIFO fill level |
| txFlush | output | 1 | TX FIFO flush and hold |
| sclHold | output | 1 | Request to stretch SCL low |

## Verification
The bench drives an event and a clear of the same bit in one cycle. A design that gives the clear priority would lose the event and show the bit as 0. It clears one bit at a time from a word with all bits set, which catches a clear strobe wired to the wrong bit or to several bits. It pushes into a full FIFO, pops an empty one and pushes while an abort is pending. A counter that wraps, or one that is not held at zero by the flush, would show a wrong `txLevel`. Finally, it toggles `engineBusy` with the controller disabled, and it fires events while disabled. A wrong design would either show bit 4 driven by the threshold compare or let sticky bits set while disabled.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_STICKY = 7;
  localparam int STAT_W     = 16;
  localparam int STICKY_LSB = 5;
  localparam int EMPTY_BIT  = 4;

  // index inside the sticky vector; status bit = STICKY_LSB + index
  localparam int STK_RDREQ   = 0;
  localparam int STK_TXABORT = 1;
  localparam int STK_RXDONE  = 2;
  localparam int STK_ACTIV   = 3;
  localparam int STK_STOP    = 4;
  localparam int STK_START   = 5;
  localparam int STK_GENCALL = 6;

  typedef struct packed {
    logic [NUM_STICKY-1:0] setMask;
    logic [NUM_STICKY-1:0] clrMask;
    logic                  holdZero;
    logic                  flush;
    logic                  inc;
    logic                  dec;
  } irq_strobe_t;
endpackage

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                  ctrlEn,
  input  logic                  engineBusy,
  input  logic [LVL_W-1:0]      txThresh,
  input  logic [NUM_STICKY-1:0] evVec,
  input  logic [NUM_STICKY-1:0] clrVec,
  input  logic                  clrAll,
  input  logic                  txPush,
  input  logic                  txPop,
  input  logic [LVL_W-1:0]      levelQ,
  input  logic                  abortQ,
  output irq_strobe_t           stb,
  output logic                  txEmpty
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(FIFO_DEPTH);

  logic flushNow;
  logic pushOk;
  logic popOk;

  always_comb begin
    flushNow = !ctrlEn || abortQ || evVec[STK_TXABORT];
    pushOk   = txPush && !flushNow && (levelQ != FULL);
    popOk    = txPop && !flushNow && (levelQ != '0);

    stb.setMask  = ctrlEn ? evVec : '0;
    stb.clrMask  = clrVec | {NUM_STICKY{clrAll}};
    stb.holdZero = !ctrlEn;
    stb.flush    = flushNow;
    stb.inc      = pushOk && !popOk;
    stb.dec      = popOk && !pushOk;

    txEmpty = ctrlEn ? (levelQ <= txThresh) : engineBusy;
  end
endmodule

// File: rtl/i2c_irq_dp.sv
module i2c_irq_dp
  import i2c_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  irq_strobe_t           stb,
  output logic [NUM_STICKY-1:0] stickyQ,
  output logic [LVL_W-1:0]      levelQ
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(FIFO_DEPTH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyQ <= '0;
    end else if (stb.holdZero) begin
      stickyQ <= '0;
    end else begin
      stickyQ <= stb.setMask | (stickyQ & ~stb.clrMask);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
    end else if (stb.flush) begin
      levelQ <= '0;
    end else if (stb.inc) begin
      levelQ <= levelQ + 1'b1;
    end else if (stb.dec) begin
      levelQ <= levelQ - 1'b1;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setMask != '0) |=> ((stickyQ & $past(stb.setMask)) == $past(stb.setMask))); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.holdZero |=> (stickyQ == '0)); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> (levelQ == '0)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    levelQ <= FULL); // R12
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlEn,
  input  logic [LVL_W-1:0]  txThresh,
  input  logic              engineBusy,
  input  logic              evGenCall,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evActivity,
  input  logic              evRxDone,
  input  logic              evTxAbort,
  input  logic              evRdReq,
  input  logic              txPush,
  input  logic              txPop,
  input  logic              clrGenCall,
  input  logic              clrStart,
  input  logic              clrStop,
  input  logic              clrActivity,
  input  logic              clrRxDone,
  input  logic              clrTxAbort,
  input  logic              clrRdReq,
  input  logic              clrAll,
  output logic [STAT_W-1:0] rawStat,
  output logic [LVL_W-1:0]  txLevel,
  output logic              txFlush,
  output logic              sclHold
);
  logic [NUM_STICKY-1:0] evVec;
  logic [NUM_STICKY-1:0] clrVec;
  logic [NUM_STICKY-1:0] stickyQ;
  logic [LVL_W-1:0]      levelQ;
  logic                  txEmpty;
  irq_strobe_t           stb;

  assign evVec  = {evGenCall, evStart, evStop, evActivity, evRxDone, evTxAbort, evRdReq};
  assign clrVec = {clrGenCall, clrStart, clrStop, clrActivity, clrRxDone, clrTxAbort, clrRdReq};

  i2c_irq_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) i_ctrl (
    .ctrlEn(ctrlEn), .engineBusy(engineBusy), .txThresh(txThresh),
    .evVec(evVec), .clrVec(clrVec), .clrAll(clrAll),
    .txPush(txPush), .txPop(txPop), .levelQ(levelQ),
    .abortQ(stickyQ[STK_TXABORT]), .stb(stb), .txEmpty(txEmpty)
  );

  i2c_irq_dp #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .stickyQ(stickyQ), .levelQ(levelQ)
  );

  always_comb begin
    rawStat = '0;
    rawStat[STICKY_LSB +: NUM_STICKY] = stickyQ;
    rawStat[EMPTY_BIT] = txEmpty;
  end

  assign txLevel = levelQ;
  assign txFlush = stb.flush;
  assign sclHold = stickyQ[STK_RDREQ];

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rawStat[15:12] == 4'h0) && (rawStat[3:0] == 4'h0)); // R2
endmodule

// File: tb/test_i2c_irq_status.sv
module test_i2c_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlEn = 1'b0;
  logic [LW-1:0] txThresh = '0;
  logic engineBusy = 1'b0;
  logic [6:0] ev = '0;
  logic [6:0] clr = '0;
  logic clrAll = 1'b0;
  logic txPush = 1'b0;
  logic txPop = 1'b0;
  logic [15:0] rawStat;
  logic [LW-1:0] txLevel;
  logic txFlush;
  logic sclHold;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_status i_i2c_irq_status (
    .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .txThresh(txThresh), .engineBusy(engineBusy),
    .evGenCall(ev[6]), .evStart(ev[5]), .evStop(ev[4]), .evActivity(ev[3]),
    .evRxDone(ev[2]), .evTxAbort(ev[1]), .evRdReq(ev[0]),
    .txPush(txPush), .txPop(txPop),
    .clrGenCall(clr[6]), .clrStart(clr[5]), .clrStop(clr[4]), .clrActivity(clr[3]),
    .clrRxDone(clr[2]), .clrTxAbort(clr[1]), .clrRdReq(clr[0]), .clrAll(clrAll),
    .rawStat(rawStat), .txLevel(txLevel), .txFlush(txFlush), .sclHold(sclHold)
  );

  // {push, pop, expected level}; threshold fixed at 2
  localparam logic [5:0] VEC [21] = '{
    {2'b10, 4'd1}, {2'b10, 4'd2}, {2'b10, 4'd3}, {2'b11, 4'd3}, {2'b01, 4'd2},
    {2'b10, 4'd3}, {2'b10, 4'd4}, {2'b10, 4'd5}, {2'b10, 4'd6}, {2'b10, 4'd7},
    {2'b10, 4'd8}, {2'b10, 4'd8}, {2'b01, 4'd7}, {2'b01, 4'd6}, {2'b01, 4'd5},
    {2'b01, 4'd4}, {2'b01, 4'd3}, {2'b01, 4'd2}, {2'b01, 4'd1}, {2'b01, 4'd0},
    {2'b01, 4'd0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] expStat;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk("R1 status", rawStat, 16'h0000);
    chk("R1 level", {12'h0, txLevel}, 16'h0000);

    // disabled: empty bit follows engine, pushes ignored
    engineBusy = 1'b1;
    #1 chk("R9 busy empty", rawStat, 16'h0010);
    txPush = 1'b1; tick(); txPush = 1'b0;
    chk("R9 push ignored", {12'h0, txLevel}, 16'h0000);
    chk("R9 flush", {15'h0, txFlush}, 16'h0001);
    engineBusy = 1'b0;
    #1 chk("R9 idle empty", rawStat, 16'h0000);

    ctrlEn = 1'b1; txThresh = 4'd2;
    tick();
    chk("R8 empty at zero", rawStat, 16'h0010);

    foreach (VEC[k]) begin
      txPush = VEC[k][5]; txPop = VEC[k][4];
      tick();
      txPush = 1'b0; txPop = 1'b0;
      chk("R12 level", {12'h0, txLevel}, {12'h0, VEC[k][3:0]});
      chk("R8 threshold", {15'h0, rawStat[4]}, {15'h0, (VEC[k][3:0] <= 4'd2)});
    end

    // each event sets its bit, holds, and its own clear removes it
    for (int i = 0; i < 7; i++) begin
      ev = 7'(1 << i); tick(); ev = '0;
      expStat = 16'h0010 | 16'(1 << (i + 5));
      chk("R3 set", rawStat, expStat);
      tick();
      chk("R3 hold", rawStat, expStat);
      clr = 7'(1 << i); tick(); clr = '0;
      chk("R4 own clear", rawStat, 16'h0010);
    end

    // all set, then clear one at a time
    ev = 7'h7F; tick(); ev = '0;
    chk("R2 all bits", rawStat, 16'h0FF0);
    expStat = 16'h0FF0;
    for (int i = 0; i < 7; i++) begin
      clr = 7'(1 << i); tick(); clr = '0;
      expStat = expStat & ~16'(1 << (i + 5));
      chk("R4 single clear", rawStat, expStat);
    end

    // clear-all
    ev = 7'h7F; tick(); ev = '0;
    clrAll = 1'b1; tick(); clrAll = 1'b0;
    chk("R5 clear all", rawStat, 16'h0010);

    // set wins against both kinds of clear
    ev = 7'h7F; tick(); ev = '0;
    ev = 7'h08; clrAll = 1'b1; tick(); ev = '0; clrAll = 1'b0;
    chk("R6 set beats clrAll", rawStat, 16'h0110);
    ev = 7'h04; clr = 7'h04; tick(); ev = '0; clr = '0;
    chk("R6 set beats own clear", rawStat, 16'h0190);
    clrAll = 1'b1; tick(); clrAll = 1'b0;

    // read request holds SCL
    ev = 7'h01; tick(); ev = '0;
    chk("R11 hold on", {15'h0, sclHold}, 16'h0001);
    tick();
    chk("R11 hold stays", {15'h0, sclHold}, 16'h0001);
    clr = 7'h01; tick(); clr = '0;
    chk("R11 hold off", {15'h0, sclHold}, 16'h0000);

    // abort flush
    txPush = 1'b1; repeat (3) tick(); txPush = 1'b0;
    chk("R12 pushed three", {12'h0, txLevel}, 16'h0003);
    ev = 7'h02; tick(); ev = '0;
    chk("R10 abort flush level", {12'h0, txLevel}, 16'h0000);
    chk("R10 abort bit", rawStat, 16'h0050);
    txPush = 1'b1; tick(); txPush = 1'b0;
    chk("R10 push while abort", {12'h0, txLevel}, 16'h0000);
    clr = 7'h02; tick(); clr = '0;
    txPush = 1'b1; tick(); txPush = 1'b0;
    chk("R10 push after clear", {12'h0, txLevel}, 16'h0001);
    txPop = 1'b1; tick(); txPop = 1'b0;

    // disable clears and blocks events
    ev = 7'h7F; tick(); ev = '0;
    ctrlEn = 1'b0; tick();
    chk("R7 disable clears", rawStat, 16'h0000);
    ev = 7'h7F; tick(); ev = '0;
    chk("R7 events ignored", rawStat, 16'h0000);
    chk("R2 reserved zero", rawStat & 16'hF00F, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule